// File: doc/BRIEF.md
# GPIO Port with Interrupt Sensing

A 32-pin general-purpose I/O port. Software programs it through a small register bank on a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Each pin can be an output, driving the value held in the data register, or an input with its output enable low. The current pin levels can always be read from the pad status register, whatever the pin's direction. Every pad input passes through a two-flop synchroniser.

Every pin can raise an interrupt. A 2-bit sense code selects low level, high level, rising edge or falling edge. The codes for the lower half of the pins sit in one configuration register and the codes for the upper half sit in a second one. A detected event latches into a status register that software clears by writing ones. The status is ANDed with a mask, and the result drives one request line for pins 0–15, one for pins 16–31 and one combined line.

The register bus accepts a write on every cycle where the strobe is high. It has no valid/ready handshake and never applies back-pressure, so a write completes at the clock edge on which it is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: The register offsets are: data 0x00, direction 0x04, pad status 0x08, lower sense configuration 0x0C, upper sense configuration 0x10, mask 0x14, status 0x18. Data, direction, both configuration registers and mask read back the value last written. Any other offset reads zero.
- R2: `pad_oe` equals the direction register (1 = output) and `pad_out` equals the data register, both from the clock edge on which the write takes effect.
- R3: The pad status register returns `pad_in` as it stood two clock edges earlier, for both input and output pins. Writes to it have no effect.
- R4: Sense code 0 (low level) and code 1 (high level) set the pin's status bit on every clock edge while the synchronised level is active. A clear therefore does not stick while the level stays active.
- R5: Sense code 2 (rising) and code 3 (falling) set the status bit once for each qualifying change of the synchronised level, seen one edge after that level changes. A level that stays put sets nothing more, and a change in the other direction sets nothing.
- R6: Pin n with n < 16 takes its code from bits [2n+1:2n] of the lower configuration register. Pin n with n >= 16 takes its code from bits [2(n-16)+1:2(n-16)] of the upper configuration register.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a set and a clear reach the same bit on the same edge, the bit ends up set.
- R8: `irq_lo` is high when any of status AND mask in bits 15:0 is nonzero. `irq_hi` does the same for bits 31:16. `irq_any` is high when either of them is high. A mask bit of 1 enables the pin.
- R9: Reset clears data, direction, mask, both configuration registers, status and the synchroniser flops. No interrupt line is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Values driven on output pins |
| pad_oe | output | 32 | Output enable per pin |
| irq_any | output | 1 | Combined interrupt request |
| irq_lo | output | 1 | Interrupt request for pins 0–15 |
| irq_hi | output | 1 | Interrupt request for pins 16–31 |

## Verification
Pins in each sense mode see a held level, a single rising step and a single falling step. This shows the difference between level sensing, which sets the status again after a clear, and edge sensing, which sets it once and never on the opposite edge. Events on a low pin and on a high pin tell the two configuration registers and the two interrupt halves apart. A clear written on exactly the edge on which an edge event lands shows whether the set wins. A zero write and a masked-off state show that neither disturbs the status or raises a line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_FALL = 2'd3
  } sense_e;

  localparam int unsigned OFS_DATA   = 0;
  localparam int unsigned OFS_DIR    = 4;
  localparam int unsigned OFS_PAD    = 8;
  localparam int unsigned OFS_CFG_LO = 12;
  localparam int unsigned OFS_CFG_HI = 16;
  localparam int unsigned OFS_MASK   = 20;
  localparam int unsigned OFS_STAT   = 24;

endpackage

// File: rtl/gpio_pad_sync.sv
// Two-flop synchroniser followed by a one-cycle history stage for edge sensing.
module gpio_pad_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign lvl   = sync_q;
  assign lvl_d = hist_q;
endmodule

// File: rtl/gpio_sense_cell.sv
// Per-pin event detector: decides whether this cycle sets the status bit.
module gpio_sense_cell
  import gpio_irq_pkg::*;
(
  input  sense_e mode,
  input  logic   lvl,
  input  logic   lvl_d,
  output logic   hit
);
  always_comb begin
    unique case (mode)
      SENSE_LOW:  hit = ~lvl;
      SENSE_HIGH: hit = lvl;
      SENSE_RISE: hit = lvl & ~lvl_d;
      SENSE_FALL: hit = ~lvl & lvl_d;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq_any,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = PINS / 2;

  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_PAD    = ADDR_W'(OFS_PAD);
  localparam logic [ADDR_W-1:0] A_CFG_LO = ADDR_W'(OFS_CFG_LO);
  localparam logic [ADDR_W-1:0] A_CFG_HI = ADDR_W'(OFS_CFG_HI);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);

  logic [PINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q;
  logic [PINS-1:0] lvl, lvl_d, stat_set, clr_vec, req;

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_DATA:   data_q   <= bus_wdata;
        A_DIR:    dir_q    <= bus_wdata;
        A_CFG_LO: cfg_lo_q <= bus_wdata;
        A_CFG_HI: cfg_hi_q <= bus_wdata;
        A_MASK:   mask_q   <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign clr_vec = (bus_wr && bus_addr == A_STAT) ? bus_wdata : '0;

  // Status: a new event outranks a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_set | (stat_q & ~clr_vec);
  end

  gpio_pad_sync #(.W(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (pad_in),
    .lvl   (lvl),
    .lvl_d (lvl_d)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    sense_e mode;
    if (p < HALF) begin : g_lo
      assign mode = sense_e'(cfg_lo_q[2*p +: 2]);
    end else begin : g_hi
      assign mode = sense_e'(cfg_hi_q[2*(p-HALF) +: 2]);
    end
    gpio_sense_cell u_cell (
      .mode  (mode),
      .lvl   (lvl[p]),
      .lvl_d (lvl_d[p]),
      .hit   (stat_set[p])
    );
  end

  // Read mux
  always_comb begin
    unique case (bus_addr)
      A_DATA:   bus_rdata = data_q;
      A_DIR:    bus_rdata = dir_q;
      A_PAD:    bus_rdata = lvl;
      A_CFG_LO: bus_rdata = cfg_lo_q;
      A_CFG_HI: bus_rdata = cfg_hi_q;
      A_MASK:   bus_rdata = mask_q;
      A_STAT:   bus_rdata = stat_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign req     = stat_q & mask_q;
  assign irq_lo  = |req[HALF-1:0];
  assign irq_hi  = |req[PINS-1:HALF];
  assign irq_any = irq_lo | irq_hi;
  assign pad_out = data_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   stat_q,
  input logic [PINS-1:0]   stat_set,
  input logic [PINS-1:0]   mask_q,
  input logic              irq_any,
  input logic              irq_lo,
  input logic              irq_hi
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  // R7
  clr_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT) |=> ((stat_q & $past(bus_wdata & ~stat_set)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_set) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(stat_set)) == '0));

  // R2
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> (pad_oe == $past(bus_wdata)));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_any);

  // R8
  halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (irq_lo || irq_hi));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .stat_q    (stat_q),
  .stat_set  (stat_set),
  .mask_q    (mask_q),
  .irq_any   (irq_any),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  // One time unit stands for 1 ns: 4-unit period, 250 MHz.
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_any, irq_lo, irq_hi;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_any(irq_any),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_data = '0, m_dir = '0, m_clo = '0, m_chi = '0, m_mask = '0, m_stat = '0;
  logic [31:0] m_s1 = '0, m_s2 = '0, m_d = '0;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_data;
      5'h04: return m_dir;
      5'h08: return m_s2;
      5'h0C: return m_clo;
      5'h10: return m_chi;
      5'h14: return m_mask;
      5'h18: return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] setv;
    logic [31:0] clr;
    logic [31:0] req;
    setv = '0;
    if (!rst_n) begin
      m_data = '0; m_dir = '0; m_clo = '0; m_chi = '0; m_mask = '0; m_stat = '0;
      m_s1 = '0; m_s2 = '0; m_d = '0;
    end else begin
      for (int p = 0; p < 32; p++) begin
        int code;
        code = (p < 16) ? int'(m_clo[2*p +: 2]) : int'(m_chi[2*(p-16) +: 2]);
        if (code == 0) setv[p] = !m_s2[p];
        else if (code == 1) setv[p] = m_s2[p];
        else if (code == 2) setv[p] = m_s2[p] && !m_d[p];
        else setv[p] = !m_s2[p] && m_d[p];
      end
      clr = (bus_wr && bus_addr == 5'h18) ? bus_wdata : 32'h0;
      m_stat = setv | (m_stat & ~clr);
      if (bus_wr) begin
        if (bus_addr == 5'h00) m_data = bus_wdata;
        if (bus_addr == 5'h04) m_dir  = bus_wdata;
        if (bus_addr == 5'h0C) m_clo  = bus_wdata;
        if (bus_addr == 5'h10) m_chi  = bus_wdata;
        if (bus_addr == 5'h14) m_mask = bus_wdata;
      end
      m_d = m_s2; m_s2 = m_s1; m_s1 = pad_in;
    end
    #1;
    req = m_stat & m_mask;
    chk("R1 rdata", bus_rdata, m_read(bus_addr));
    chk("R2 pad_out", pad_out, m_data);
    chk("R2 pad_oe", pad_oe, m_dir);
    chk("R8 irq", {29'h0, irq_any, irq_hi, irq_lo},
        {29'h0, |req, |req[31:16], |req[15:0]});
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    rd_chk("R9 mask after reset", 5'h14, 32'h0);
    rd_chk("R9 data after reset", 5'h00, 32'h0);
    chk("R9 irq_any after reset", {31'h0, irq_any}, 32'h0);
    rst_n = 1'b1;
    settle();
    // R4 default low-level sense with low pads sets every bit
    rd_chk("R4 low level sets all", 5'h18, 32'hFFFF_FFFF);
    chk("R8 masked off stays quiet", {31'h0, irq_any}, 32'h0);
    // R6 pin 5 high level, rest of low half rising, upper half falling
    wr(5'h0C, 32'hAAAA_A6AA);
    wr(5'h10, 32'hFFFF_FFFF);
    rd_chk("R1 cfg_lo readback", 5'h0C, 32'hAAAA_A6AA);
    rd_chk("R1 cfg_hi readback", 5'h10, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    rd_chk("R7 clear all", 5'h18, 32'h0);
    wr(5'h14, 32'hFFFF_FFFF);
    rd_chk("R1 mask readback", 5'h14, 32'hFFFF_FFFF);
    // R5 rising edge on pin 3
    @(negedge clk); pad_in[3] = 1'b1;
    settle();
    rd_chk("R5 rise pin3", 5'h18, 32'h0000_0008);
    chk("R8 low half line", {29'h0, irq_any, irq_hi, irq_lo}, 32'h5);
    wr(5'h18, 32'h0);
    rd_chk("R7 zero write keeps", 5'h18, 32'h0000_0008);
    wr(5'h18, 32'h0000_0008);
    repeat (4) @(negedge clk);
    rd_chk("R5 held level no re-set", 5'h18, 32'h0);
    // R5 and R6 falling sense on pin 20
    @(negedge clk); pad_in[20] = 1'b1;
    settle();
    rd_chk("R5 rise ignored on fall pin", 5'h18, 32'h0);
    @(negedge clk); pad_in[20] = 1'b0;
    settle();
    rd_chk("R5 fall pin20", 5'h18, 32'h0010_0000);
    chk("R8 high half line", {29'h0, irq_any, irq_hi, irq_lo}, 32'h6);
    wr(5'h18, 32'h0010_0000);
    // R4 high level on pin 5 re-sets after clear
    @(negedge clk); pad_in[5] = 1'b1;
    settle();
    wr(5'h18, 32'h0000_0020);
    rd_chk("R4 level re-sets after clear", 5'h18, 32'h0000_0020);
    @(negedge clk); pad_in[5] = 1'b0;
    settle();
    wr(5'h18, 32'h0000_0020);
    rd_chk("R4 clear sticks once inactive", 5'h18, 32'h0);
    // R7 set and clear on the same edge: set wins
    @(negedge clk); pad_in[7] = 1'b1;
    @(negedge clk);
    wr(5'h18, 32'h0000_0080);
    rd_chk("R7 set wins over clear", 5'h18, 32'h0000_0080);
    wr(5'h14, 32'h0);
    chk("R8 mask zero quiet", {31'h0, irq_any}, 32'h0);
    // R2 direction and data
    wr(5'h04, 32'h0000_FFFF);
    wr(5'h00, 32'h1234_5678);
    chk("R2 oe", pad_oe, 32'h0000_FFFF);
    chk("R2 out", pad_out, 32'h1234_5678);
    rd_chk("R1 dir readback", 5'h04, 32'h0000_FFFF);
    // R3 pad status regardless of direction, write ignored
    @(negedge clk); pad_in = 32'hCAFE_00A5;
    repeat (2) @(posedge clk);
    rd_chk("R3 pad status", 5'h08, 32'hCAFE_00A5);
    wr(5'h08, 32'h0);
    rd_chk("R3 write ignored", 5'h08, 32'hCAFE_00A5);
    rd_chk("R1 unmapped reads zero", 5'h1C, 32'h0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule